// File: doc/BRIEF.md
# Burst Memory Data-Side Write and Drive Control

This block sits on the data side of a synchronous burst memory organised as four byte lanes. Each lane is nine bits wide: eight data bits plus one parity bit. On every rising clock edge it samples the write controls and decodes them into one write strobe per lane. A single strobe covers both the data bits and the parity bit of its lane. On the same edge it captures the whole data bus into a write-data register. The strobes and the captured word are presented together during the following cycle, so the storage array can commit them.

The block also decides whether the bidirectional data and parity pins are driven. The output-enable input is asynchronous and active low, and it acts without waiting for a clock. The drive is also blocked by the cycle state: a write in flight, the first cycle after the part leaves the deselected state, and any cycle in which the part is deselected. When the drive is blocked, the outgoing bus is held at zero. When it is allowed, the bus carries the array word for the address sampled at the previous edge.

Top module: `burst_dio`

## Requirements
- R1: When `chipSel` is high and `gwN` is low at a rising edge, every bit of `laneWe` is 1 in the following cycle, whatever the values of `bweN` and `bwN`.
- R2: When `chipSel` is high, `gwN` is high and `bweN` is low at a rising edge, `laneWe` equals the bitwise inverse of the sampled `bwN` in the following cycle. Bit i of `bwN` controls lane i.
- R3: When `chipSel` is high and both `gwN` and `bweN` are high at a rising edge, the cycle is a read and `laneWe` is all zero in the following cycle.
- R4: When `chipSel` is low at a rising edge, `laneWe` is all zero in the following cycle.
- R5: `wrData` holds the value of `dqIn` sampled at the most recent rising edge. Lane i occupies bits [9i+8:9i], and the parity bit of lane i is bit 9i+8.
- R6: While `oeN` is high, `dqDrive` is 0. A change of `oeN` takes effect without a clock edge.
- R7: `dqDrive` is 0 in the cycle after an edge that produced a nonzero `laneWe`. It is also 0 while the present inputs request a write, meaning `chipSel` is high and either `gwN` is low, or `bweN` is low with at least one `bwN` bit low.
- R8: `dqDrive` is 0 in the first cycle after an edge that sampled `chipSel` high when the edge before it sampled `chipSel` low.
- R9: `dqDrive` is 0 in any cycle that follows an edge which sampled `chipSel` low.
- R10: `dqOut` equals `memQ` while `dqDrive` is 1, and is all zero otherwise.
- R11: During reset `laneWe`, `wrData` and `dqDrive` are all zero. The first cycle after reset counts as following a deselected cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Present cycle is a selected access |
| gwN | input | 1 | Write all lanes, active low |
| bweN | input | 1 | Enable per-lane writes, active low |
| bwN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | 36 | Data and parity arriving from the pins |
| memQ | input | 36 | Read word from the storage array |
| laneWe | output | 4 | Registered per-lane write strobes |
| wrData | output | 36 | Registered write data |
| dqOut | output | 36 | Data and parity toward the pins |
| dqDrive | output | 1 | Drive enable for the data and parity pins |

## Verification
Lane-strobe decoding and output masking can fall in the same cycle. A new write request arrives while the previous edge's result still decides the drive. This can happen right after a deselect, or right after another write. The sweep walks every combination of `gwN`, `bweN`, `bwN` and `chipSel` over consecutive cycles, so reads, writes and deselects meet in every order. At each step the bench checks the registered strobes and data after the edge. In mid-cycle it checks the drive against the new request and the previous two select samples, and then again after it lifts `oeN` with no clock.

// File: rtl/burst_dio_pkg.sv
package burst_dio_pkg;
  localparam int LANES = 4;

  // Strobes passed from control to the datapath
  typedef struct packed {
    logic [LANES-1:0] laneWe;
    logic             drive;
  } dioStrb_t;
endpackage

// File: rtl/burst_dio_ctl.sv
module burst_dio_ctl
  import burst_dio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  output dioStrb_t         strb
);
  logic [LANES-1:0] laneDec;
  logic [LANES-1:0] laneWeQ;
  logic             selQ;
  logic             prevSelQ;
  logic             wrReqNow;
  logic             wrCycQ;

  // Per-lane decode: global write overrides the lane selects
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (!chipSel)      laneDec[i] = 1'b0;
      else if (!gwN)     laneDec[i] = 1'b1;
      else if (!bweN)    laneDec[i] = ~bwN[i];
      else               laneDec[i] = 1'b0;
    end
  end

  assign wrReqNow = |laneDec;
  assign wrCycQ   = |laneWeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneWeQ  <= '0;
      selQ     <= 1'b0;
      prevSelQ <= 1'b0;
    end else begin
      laneWeQ  <= laneDec;
      selQ     <= chipSel;
      prevSelQ <= selQ;
    end
  end

  // Drive needs oe, a selected cycle that did not follow a deselect,
  // and no write either registered or being requested now
  always_comb begin
    strb.laneWe = laneWeQ;
    strb.drive  = !oeN && selQ && prevSelQ && !wrCycQ && !wrReqNow;
  end
endmodule

// File: rtl/burst_dio_path.sv
module burst_dio_path
  import burst_dio_pkg::*;
#(
  parameter int LANE_BITS = 9,
  localparam int DW = LANES * LANE_BITS
)(
  input  logic             clk,
  input  logic             rstN,
  input  dioStrb_t         strb,
  input  logic [DW-1:0]    dqIn,
  input  logic [DW-1:0]    memQ,
  output logic [LANES-1:0] laneWe,
  output logic [DW-1:0]    wrData,
  output logic [DW-1:0]    dqOut,
  output logic             dqDrive
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_BITS-1:0] capQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capQ <= '0;
      else       capQ <= dqIn[i*LANE_BITS +: LANE_BITS];
    end

    assign wrData[i*LANE_BITS +: LANE_BITS] = capQ;
    assign dqOut[i*LANE_BITS +: LANE_BITS] =
      strb.drive ? memQ[i*LANE_BITS +: LANE_BITS] : '0;
  end

  assign laneWe  = strb.laneWe;
  assign dqDrive = strb.drive;
endmodule

// File: rtl/burst_dio.sv
module burst_dio
  import burst_dio_pkg::*;
#(
  parameter int LANE_BITS = 9,
  localparam int DW = LANES * LANE_BITS
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  input  logic [DW-1:0]    dqIn,
  input  logic [DW-1:0]    memQ,
  output logic [LANES-1:0] laneWe,
  output logic [DW-1:0]    wrData,
  output logic [DW-1:0]    dqOut,
  output logic             dqDrive
);
  dioStrb_t strb;

  burst_dio_ctl u_ctl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .strb(strb)
  );

  burst_dio_path #(.LANE_BITS(LANE_BITS)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .dqIn(dqIn), .memQ(memQ),
    .laneWe(laneWe), .wrData(wrData), .dqOut(dqOut), .dqDrive(dqDrive)
  );
endmodule

// File: rtl/burst_dio_chk.sv
module burst_dio_chk
  import burst_dio_pkg::*;
#(
  parameter int LANE_BITS = 9,
  localparam int DW = LANES * LANE_BITS
)(
  input logic             clk,
  input logic             rstN,
  input logic             chipSel,
  input logic             gwN,
  input logic             bweN,
  input logic             oeN,
  input logic [DW-1:0]    dqIn,
  input logic [DW-1:0]    memQ,
  input logic [LANES-1:0] laneWe,
  input logic [DW-1:0]    wrData,
  input logic [DW-1:0]    dqOut,
  input logic             dqDrive
);
  // R1
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipSel && !gwN |=> laneWe == {LANES{1'b1}});
  // R3
  read_no_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipSel && gwN && bweN |=> laneWe == '0);
  // R4
  desel_no_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> laneWe == '0);
  // R5
  data_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> wrData == $past(dqIn));
  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqDrive);
  // R7
  write_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneWe != '0 |-> !dqDrive);
  // R8
  first_sel_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel ##1 chipSel |=> !dqDrive);
  // R9
  desel_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !dqDrive);
  // R10
  out_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dqDrive |-> dqOut == '0);
  // R10
  out_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqDrive |-> dqOut == memQ);
endmodule

bind burst_dio burst_dio_chk #(.LANE_BITS(LANE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .gwN(gwN), .bweN(bweN),
  .oeN(oeN), .dqIn(dqIn), .memQ(memQ), .laneWe(laneWe), .wrData(wrData),
  .dqOut(dqOut), .dqDrive(dqDrive)
);

// File: tb/burst_dio_test.sv
module burst_dio_test;
  localparam int LN = 4;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, gwN = 1'b1, bweN = 1'b1, oeN = 1'b1;
  logic [LN-1:0] bwN = '1;
  logic [DW-1:0] dqIn = '0, memQ = '0;
  logic [LN-1:0] laneWe;
  logic [DW-1:0] wrData, dqOut;
  logic dqDrive;

  int checks = 0;
  int errors = 0;

  // model state
  logic selQ = 1'b0, prevSel = 1'b0, wrQ = 1'b0;

  burst_dio uut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .dqIn(dqIn), .memQ(memQ), .laneWe(laneWe),
    .wrData(wrData), .dqOut(dqOut), .dqDrive(dqDrive)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [LN-1:0] expLane;
    logic wrNow, expDrv;
    #7;
    // R11 reset state
    check("R11 laneWe", 64'(laneWe), 64'h0);
    check("R11 wrData", 64'(wrData), 64'h0);
    check("R11 dqDrive", 64'(dqDrive), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    for (int idx = 0; idx < 512; idx++) begin
      @(negedge clk);
      bwN     = idx[3:0];
      bweN    = idx[4];
      gwN     = idx[5];
      chipSel = !(idx[7:6] == 2'b01 && idx[5:4] != 2'b11) && !(idx[6] && idx[2:0] == 3'd7);
      oeN     = idx[8] & idx[0];
      dqIn    = 36'(idx) * 36'h1F3A7 + 36'h123;
      memQ    = ~dqIn ^ 36'(idx << 9);
      #1;
      wrNow  = chipSel && (!gwN || (!bweN && bwN != '1));
      expDrv = !oeN && selQ && prevSel && !wrQ && !wrNow;
      // R6 R7 R8 R9 combined drive rule
      check(wrNow ? "R7 drive on write request" :
            (!selQ ? "R9 drive while deselected" :
            (!prevSel ? "R8 drive first after deselect" :
            (wrQ ? "R7 drive after write" : "R6 drive vs oe"))),
            64'(dqDrive), 64'(expDrv));
      // R10
      check("R10 dqOut", 64'(dqOut), expDrv ? 64'(memQ) : 64'h0);
      // R6 async lift of oe
      oeN = 1'b1;
      #0.5;
      check("R6 oe high blocks drive", 64'(dqDrive), 64'h0);
      check("R10 dqOut zero when off", 64'(dqOut), 64'h0);
      oeN = idx[8] & idx[0];
      // expected strobes
      if (!chipSel)    expLane = '0;
      else if (!gwN)   expLane = '1;
      else if (!bweN)  expLane = ~bwN;
      else             expLane = '0;
      @(posedge clk);
      #1;
      if (!chipSel)      check("R4 deselect strobes", 64'(laneWe), 64'(expLane));
      else if (!gwN)     check("R1 global write", 64'(laneWe), 64'(expLane));
      else if (!bweN)    check("R2 byte write", 64'(laneWe), 64'(expLane));
      else               check("R3 read strobes", 64'(laneWe), 64'(expLane));
      check("R5 write data", 64'(wrData), 64'(dqIn));
      prevSel = selQ;
      selQ    = chipSel;
      wrQ     = (expLane != '0);
    end
    finishRun();
  end
endmodule